// File: doc/BRIEF.md
# Single-Cycle Eight-Instruction Processor Core

This block is a small processor core that completes one instruction on every rising clock edge. It fetches a 32-bit instruction word at the program counter and decodes it. It reads two operands from a 32 x 32-bit register file, runs them through an ALU and optionally reads or writes data memory. The result is written back and the program counter advances in the same edge. The core knows five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), a word load, a word store and a branch taken on equality.

Instruction and data storage are internal word arrays. Reads from them are combinational and writes land on the clock edge. While the core is held in reset, a loader port fills either array one word at a time. After reset is released, the core runs on its own. It exposes the program counter, the current instruction and a trace of every register-file write for observation.

Top module: `onecycle_cpu`

## Requirements
- R1: While `rst` is high, the next rising edge sets the program counter to 0. No register or data-memory write from the core happens while `rst` is high. `wb_valid` is low during reset.
- R2: R-type instructions use opcode 0, with `rs` at bits 25:21, `rt` at 20:16 and `rd` at 15:11. The function code in bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or. The core writes R[rd] = R[rs] op R[rt], with 32-bit wrap-around.
- R3: Function code 0x2A writes 1 to R[rd] when R[rs] is less than R[rt] as signed two's-complement numbers, and writes 0 otherwise.
- R4: Opcode 0x23 loads the data word at byte address R[rs] + sign-extended bits 15:0 into R[rt]. The word index is address bits [AW+1:2].
- R5: Opcode 0x2B stores R[rt] at byte address R[rs] + sign-extended offset. It writes no register. A later load from that address returns the stored value.
- R6: Opcode 0x04 compares R[rs] with R[rt]. When they are equal, the next PC is PC + 4 + (sign-extended offset << 2). Otherwise it is PC + 4.
- R7: Register 0 always reads as zero. A write aimed at register 0 is dropped and does not show on the trace.
- R8: Any other opcode, and any R-type function code other than the five listed, acts as a no-op. It writes no register and no memory, and the PC advances by 4.
- R9: `instr_o` shows the instruction word at word index PC[AW+1:2]. Every non-branching instruction advances the PC by 4.
- R10: An instruction that reads and writes the same register uses that register's old value. The new value is seen by the following instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state element updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_imem_we | input | 1 | Loader write strobe for instruction memory |
| ld_dmem_we | input | 1 | Loader write strobe for data memory |
| ld_addr | input | AW | Loader word index |
| ld_data | input | 32 | Loader write data |
| pc_o | output | 32 | Current program counter (byte address) |
| instr_o | output | 32 | Instruction at the current PC |
| wb_valid | output | 1 | A register write commits on the coming edge |
| wb_addr | output | 5 | Register being written |
| wb_data | output | 32 | Value being written |

## Verification
Two actions can fall into one cycle: reading a register as an operand and writing a new value into that same register. The program includes an add whose destination is also both of its sources, so the read and the write hit one register in one cycle. The behavioural reference model checks that the traced value is built from the old contents and that only the next instruction sees the new one. A second case pairs a store with a load from the same address on the next cycle. This confirms the clocked memory write is visible at once to the combinational read that follows.

// File: rtl/onecycle_cpu.sv
module onecycle_cpu #(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_imem_we,
  input  logic          ld_dmem_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [31:0]   ld_data,
  output logic [31:0]   pc_o,
  output logic [31:0]   instr_o,
  output logic          wb_valid,
  output logic [4:0]    wb_addr,
  output logic [31:0]   wb_data
);
  localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B, OP_BEQ = 6'h04;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24, F_OR = 6'h25, F_SLT = 6'h2A;

  typedef enum logic [2:0] {A_ADD, A_SUB, A_AND, A_OR, A_SLT} alu_op_e;

  logic [31:0] pc;
  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];
  logic [31:0] rf   [32];
  logic [31:0] instr;

  assign instr = imem[pc[AW+1:2]];

  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm;
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];

  logic    reg_wr, mem_wr, alu_src, mem_to_reg, branch, dst_rd, known;
  alu_op_e alu_ctr;

  always_comb begin
    reg_wr = 1'b0; mem_wr = 1'b0; alu_src = 1'b0; mem_to_reg = 1'b0;
    branch = 1'b0; dst_rd = 1'b0; known = 1'b1; alu_ctr = A_ADD;
    case (opcode)
      OP_R: begin
        reg_wr = 1'b1; dst_rd = 1'b1;
        case (funct)
          F_ADD: alu_ctr = A_ADD;
          F_SUB: alu_ctr = A_SUB;
          F_AND: alu_ctr = A_AND;
          F_OR:  alu_ctr = A_OR;
          F_SLT: alu_ctr = A_SLT;
          default: begin reg_wr = 1'b0; known = 1'b0; end
        endcase
      end
      OP_LW:  begin reg_wr = 1'b1; alu_src = 1'b1; mem_to_reg = 1'b1; end
      OP_SW:  begin mem_wr = 1'b1; alu_src = 1'b1; end
      OP_BEQ: begin branch = 1'b1; alu_ctr = A_SUB; end
      default: known = 1'b0;
    endcase
  end

  logic [31:0] bus_a, bus_b, sext, opnd_b, alu_res, dmem_rd, wb;
  logic [4:0]  wr_addr;
  logic        rf_we, zero;

  assign bus_a  = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign bus_b  = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign sext   = {{16{imm[15]}}, imm};
  assign opnd_b = alu_src ? sext : bus_b;

  always_comb begin
    case (alu_ctr)
      A_SUB:   alu_res = bus_a - opnd_b;
      A_AND:   alu_res = bus_a & opnd_b;
      A_OR:    alu_res = bus_a | opnd_b;
      A_SLT:   alu_res = {31'd0, $signed(bus_a) < $signed(opnd_b)};
      default: alu_res = bus_a + opnd_b;
    endcase
  end

  assign zero    = (alu_res == 32'd0);
  assign dmem_rd = dmem[alu_res[AW+1:2]];
  assign wb      = mem_to_reg ? dmem_rd : alu_res;
  assign wr_addr = dst_rd ? rd : rt;
  assign rf_we   = reg_wr && (wr_addr != 5'd0) && !rst;

  logic [31:0] pc_seq, pc_br, pc_next;
  assign pc_seq  = pc + 32'd4;
  assign pc_br   = pc_seq + {sext[29:0], 2'b00};
  assign pc_next = (branch && zero) ? pc_br : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (rf_we) begin
      rf[wr_addr] <= wb;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_imem_we) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_dmem_we)          dmem[ld_addr] <= ld_data;
    else if (mem_wr && !rst) dmem[alu_res[AW+1:2]] <= bus_b;
  end

  assign pc_o     = pc;
  assign instr_o  = instr;
  assign wb_valid = rf_we;
  assign wb_addr  = wr_addr;
  assign wb_data  = wb;

  p_reset_pc_r1: assert property (@(posedge clk) $past(rst) |-> pc == 32'd0);
  p_seq_pc_r9: assert property (@(posedge clk) disable iff (rst)
    !(branch && zero) |=> pc == $past(pc) + 32'd4);
  p_beq_target_r6: assert property (@(posedge clk) disable iff (rst)
    (branch && zero) |=> pc == $past(pc_br));
  p_noop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !known |-> !rf_we && !mem_wr && !branch);
  p_slt_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (rf_we && alu_ctr == A_SLT) |-> wb[31:1] == 31'd0);
  p_store_noreg_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !rf_we);
endmodule

// File: tb/onecycle_cpu_tb.sv
module onecycle_cpu_tb_top;
  localparam int MEM_WORDS = 64;
  localparam int AW = $clog2(MEM_WORDS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, instr_o, wb_data;
  logic wb_valid;
  logic [4:0] wb_addr;

  always #10 clk = ~clk;

  onecycle_cpu #(.MEM_WORDS(MEM_WORDS)) dut_i (
    .clk(clk), .rst(rst), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_imem [MEM_WORDS];
  logic [31:0] m_dmem [MEM_WORDS];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;

  function automatic logic [31:0] rtype(int s, int t, int d, logic [5:0] f);
    return {6'h00, s[4:0], t[4:0], d[4:0], 5'd0, f};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] op, int s, int t, int im);
    return {op, s[4:0], t[4:0], im[15:0]};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s pc=%0h actual=%h expected=%h", tag, what, m_pc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic step_and_compare();
    logic [31:0] ins, a, b, se, res, npc;
    logic [5:0] op, fn;
    int s, t, d;
    bit we, known;
    int wa;
    string tag;
    ins = m_imem[m_pc[AW+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    s = ins[25:21]; t = ins[20:16]; d = ins[15:11];
    a = m_rf[s]; b = m_rf[t];
    se = {{16{ins[15]}}, ins[15:0]};
    we = 0; wa = 0; res = 0; known = 1; npc = m_pc + 4; tag = "R9";
    if (op == 6'h00) begin
      wa = d; we = 1; tag = "R2";
      case (fn)
        6'h20: res = a + b;
        6'h22: res = a - b;
        6'h24: res = a & b;
        6'h25: res = a | b;
        6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
        default: begin we = 0; known = 0; tag = "R8"; end
      endcase
    end else if (op == 6'h23) begin
      wa = t; we = 1; res = m_dmem[(a + se) >> 2]; tag = "R4";
    end else if (op == 6'h2B) begin
      tag = "R5";
    end else if (op == 6'h04) begin
      tag = "R6";
      if (a == b) npc = m_pc + 4 + (se << 2);
    end else begin
      known = 0; tag = "R8";
    end
    if (we && wa == 0) begin we = 0; tag = "R7"; end
    if (we && (wa == s || wa == t)) tag = "R10";
    check("R9", "instr_o", instr_o, ins);
    check(tag, "wb_valid", {31'd0, wb_valid}, {31'd0, we});
    if (we) begin
      check(tag, "wb_addr", {27'd0, wb_addr}, wa);
      check(tag, "wb_data", wb_data, res);
    end
    if (we) m_rf[wa] = res;
    if (op == 6'h2B) m_dmem[(a + se) >> 2] = b;
    m_pc = npc;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) begin m_imem[i] = 32'd0; m_dmem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    m_dmem[0] = 32'd5;
    m_dmem[1] = 32'hFFFF_FFFD;
    m_imem[0]  = itype(6'h23, 0, 1, 0);
    m_imem[1]  = itype(6'h23, 0, 2, 4);
    m_imem[2]  = rtype(1, 2, 3, 6'h20);
    m_imem[3]  = rtype(1, 2, 4, 6'h22);
    m_imem[4]  = rtype(1, 2, 5, 6'h24);
    m_imem[5]  = rtype(1, 2, 6, 6'h25);
    m_imem[6]  = rtype(2, 1, 7, 6'h2A);
    m_imem[7]  = rtype(1, 2, 8, 6'h2A);
    m_imem[8]  = itype(6'h2B, 0, 4, 8);
    m_imem[9]  = itype(6'h23, 0, 9, 8);
    m_imem[10] = rtype(1, 1, 0, 6'h20);
    m_imem[11] = rtype(0, 0, 10, 6'h20);
    m_imem[12] = itype(6'h04, 1, 2, 5);
    m_imem[13] = itype(6'h04, 3, 3, 1);
    m_imem[14] = rtype(1, 1, 11, 6'h20);
    m_imem[15] = 32'hFC00_0000;
    m_imem[16] = itype(6'h23, 4, 12, -4);
    m_imem[17] = rtype(1, 1, 1, 6'h20);
    m_imem[18] = rtype(1, 2, 13, 6'h3F);
    m_imem[19] = rtype(13, 1, 14, 6'h20);
    m_imem[20] = itype(6'h04, 0, 0, -1);
    m_pc = 32'd0;

    @(negedge clk);
    for (int i = 0; i < MEM_WORDS; i++) begin
      ld_imem_we = 1; ld_dmem_we = 1; ld_addr = i[AW-1:0];
      ld_data = m_imem[i];
      ld_dmem_we = 0;
      @(negedge clk);
      ld_imem_we = 0; ld_dmem_we = 1; ld_data = m_dmem[i];
      @(negedge clk);
    end
    ld_imem_we = 0; ld_dmem_we = 0;
    #1;
    check("R1", "pc_o in reset", pc_o, 32'd0);
    check("R1", "wb_valid in reset", {31'd0, wb_valid}, 32'd0);
    @(negedge clk);
    rst = 0;
    for (int c = 0; c < 40; c++) begin
      #1;
      check(m_pc != pc_o && c > 13 ? "R6" : "R9", "pc_o", pc_o, m_pc);
      step_and_compare();
      @(negedge clk);
    end
    rst = 1;
    @(negedge clk);
    #1;
    check("R1", "pc_o after second reset", pc_o, 32'd0);
    finish_run();
  end
endmodule